// File: doc/BRIEF.md
# Prioritized Pending Interrupt Arbiter

This block keeps one pending flag for each of twelve asynchronous interrupt sources. A source becomes pending on a one-cycle set pulse. It leaves the pending state when software pulses its clear line or when the arbiter delivers it. In each cycle the block looks at the pending flags, masks them with two enable bits taken from the processor state, and picks at most one source by a fixed priority.

The chosen source is delivered as a one-cycle take strobe together with an exception code. Both go to the exception entry sequencer downstream. While that sequencer reports busy, nothing is granted.

Three classes of source share one priority order. System reset and machine check are never masked. The critical input is masked by the critical-enable bit. The remaining nine sources are masked by the external-enable bit. Two level-style inputs, the critical input and the external input, stay pending after delivery, so they are taken again until their requester clears them.

Top module: `irq_arbiter`

## Requirements
- R1: Source bit 0 (system reset, code 0) has the highest priority. It is taken whatever the enable bits are, and its pending flag clears when it is taken.
- R2: Source bit 1 (machine check, code 1) is second in priority. It is taken whatever the enable bits are, and its pending flag clears when it is taken.
- R3: Source bit 2 (critical input, code 2) is taken only while `crit_en` is 1. Its pending flag is not cleared by being taken.
- R4: While `ext_en` is 1, the sources at bits 3 to 11 are taken in rising bit order. The order is watchdog (3), critical doorbell (4), fixed-interval timer (5), programmable interval timer (6), decrementer (7), external input (8), doorbell (9), performance monitor (10) and thermal (11). Each is delivered with its bit index as its code. While `ext_en` is 0, none of these sources is taken.
- R5: The external input (bit 8) stays pending after it is taken. Every other source gated by `ext_en` clears its pending flag when it is taken.
- R6: At most one source is granted per cycle. `take` is high for one cycle per grant, and `code` is 0 whenever `take` is low.
- R7: If a set pulse and a clear (software or take) hit the same source in the same cycle, the source ends up pending.
- R8: No grant is made in a cycle where `seq_busy` is high. Pending flags are kept until `seq_busy` falls.
- R9: A pulse on `clr_src[k]` with no set on that bit removes the pending flag, so the source is not taken later.
- R10: After reset `take` and `code` are 0. A set pulse sampled at one clock edge produces `take` after the next edge, provided the source is enabled, is the highest pending source and `seq_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| set_src | input | 12 | One-cycle set pulses, one bit per source |
| clr_src | input | 12 | One-cycle software clear pulses, one bit per source |
| crit_en | input | 1 | Critical-enable bit, gates source 2 |
| ext_en | input | 1 | External-enable bit, gates sources 3 to 11 |
| seq_busy | input | 1 | Downstream sequencer busy, blocks grants |
| take | output | 1 | One-cycle delivery strobe |
| code | output | 4 | Code of the delivered source (its bit index) |

## Verification
The assertions check the following on every cycle:
- the grant vector is one-hot or empty;
- no delivery follows a busy cycle;
- no delivery follows a cycle in which its enable bit was off;
- set beats clear on every bit;
- each non-sticky source drops out of the pending state when it is granted, while the two sticky ones stay.

Only the bench scenarios can show the absolute priority sequence across several sources, the two-edge latency from set to take, and that a cleared or masked source is never delivered later.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NSRC   = 12;
  localparam int CODE_W = $clog2(NSRC);

  // Source bit positions; the bit index is also the priority rank and code.
  localparam int SRC_RESET = 0;
  localparam int SRC_MCHK  = 1;
  localparam int SRC_CRIT  = 2;
  localparam int SRC_EXT   = 8;
  localparam int FIRST_EE  = 3;

  typedef enum logic [1:0] {
    GATE_NONE = 2'd0,
    GATE_CE   = 2'd1,
    GATE_EE   = 2'd2
  } gate_e;

  function automatic gate_e gate_of(input int idx);
    if (idx < SRC_CRIT)       return GATE_NONE;
    else if (idx == SRC_CRIT) return GATE_CE;
    else                      return GATE_EE;
  endfunction

  // Level-style sources stay pending after they are taken.
  function automatic bit sticky_of(input int idx);
    return (idx == SRC_CRIT) || (idx == SRC_EXT);
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NSRC = irq_arb_pkg::NSRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_src,
  input  logic [NSRC-1:0] clr_src,
  input  logic [NSRC-1:0] grant,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_d;
  logic [NSRC-1:0] pend_en;
  logic            past_ok_q;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    localparam bit STICKY = irq_arb_pkg::sticky_of(k);
    logic take_clr;

    if (STICKY) begin : g_level
      assign take_clr = 1'b0;
    end else begin : g_pulse
      assign take_clr = grant[k];
    end

    // Set has precedence over any kind of clear.
    always_comb begin
      pend_en[k] = set_src[k] | clr_src[k] | take_clr;
      pend_d[k]  = set_src[k] | (pend_q[k] & ~clr_src[k] & ~take_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[k] <= 1'b0;
      end else if (pend_en[k]) begin
        pend_q[k] <= pend_d[k];
      end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok_q && $past(set_src[k])) |-> pend_q[k]); // R7

    if (STICKY) begin : g_chk_level
      AST_LEVEL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(grant[k] && pend_q[k] && !clr_src[k])) |-> pend_q[k]); // R5
    end else begin : g_chk_pulse
      AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(grant[k] && !set_src[k])) |-> !pend_q[k]); // R5
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok_q <= 1'b0;
    else        past_ok_q <= 1'b1;
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NSRC   = irq_arb_pkg::NSRC,
  parameter int CODE_W = irq_arb_pkg::CODE_W
) (
  input  logic              [NSRC-1:0] pend,
  input  logic                         crit_en,
  input  logic                         ext_en,
  input  logic                         seq_busy,
  output logic              [NSRC-1:0] grant,
  output logic              [CODE_W-1:0] grant_code,
  output logic                         grant_any
);
  import irq_arb_pkg::*;

  logic [NSRC-1:0] eligible;

  for (genvar k = 0; k < NSRC; k++) begin : g_mask
    localparam gate_e GATE = gate_of(k);
    if (GATE == GATE_NONE) begin : g_free
      assign eligible[k] = pend[k];
    end else if (GATE == GATE_CE) begin : g_ce
      assign eligible[k] = pend[k] & crit_en;
    end else begin : g_ee
      assign eligible[k] = pend[k] & ext_en;
    end
  end

  // Lowest index wins; nothing is granted while the sequencer is busy.
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (!found && eligible[k] && !seq_busy) begin
        grant[k] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    grant_code = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (grant[k]) grant_code = grant_code | CODE_W'(k);
    end
  end

  assign grant_any = |grant;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC   = irq_arb_pkg::NSRC,
  parameter int CODE_W = irq_arb_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   set_src,
  input  logic [NSRC-1:0]   clr_src,
  input  logic              crit_en,
  input  logic              ext_en,
  input  logic              seq_busy,
  output logic              take,
  output logic [CODE_W-1:0] code
);
  logic              rst_i_n;
  logic [NSRC-1:0]   pend;
  logic [NSRC-1:0]   grant;
  logic [CODE_W-1:0] grant_code;
  logic              grant_any;
  logic              take_q;
  logic [CODE_W-1:0] code_q;
  logic              past_ok_q;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  irq_pend_bank #(.NSRC(NSRC)) u_bank (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .set_src (set_src),
    .clr_src (clr_src),
    .grant   (grant),
    .pend    (pend)
  );

  irq_prio_pick #(.NSRC(NSRC), .CODE_W(CODE_W)) u_pick (
    .pend       (pend),
    .crit_en    (crit_en),
    .ext_en     (ext_en),
    .seq_busy   (seq_busy),
    .grant      (grant),
    .grant_code (grant_code),
    .grant_any  (grant_any)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      take_q    <= 1'b0;
      code_q    <= '0;
      past_ok_q <= 1'b0;
    end else begin
      take_q    <= grant_any;
      code_q    <= grant_code;
      past_ok_q <= 1'b1;
    end
  end

  assign take = take_q;
  assign code = code_q;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(grant)); // R6

  AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_i_n)
    !take |-> (code == '0)); // R6

  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_i_n)
    (past_ok_q && take) |-> !$past(seq_busy)); // R8

  AST_CE_GATE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (past_ok_q && take && code == CODE_W'(irq_arb_pkg::SRC_CRIT)) |-> $past(crit_en)); // R3

  AST_EE_GATE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (past_ok_q && take && code >= CODE_W'(irq_arb_pkg::FIRST_EE)) |-> $past(ext_en)); // R4
endmodule

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
  localparam int NS = 12;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] set_src;
  logic [NS-1:0] clr_src;
  logic          crit_en;
  logic          ext_en;
  logic          seq_busy;
  logic          take;
  logic [3:0]    code;

  int total;
  int bad;
  bit done;

  irq_arbiter uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_src  (set_src),
    .clr_src  (clr_src),
    .crit_en  (crit_en),
    .ext_en   (ext_en),
    .seq_busy (seq_busy),
    .take     (take),
    .code     (code)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp_take, input logic [3:0] exp_code);
    total++;
    if (take !== exp_take || code !== exp_code) begin
      bad++;
      $display("FAIL %s: take=%0b code=%0d expected take=%0b code=%0d",
               req, take, code, exp_take, exp_code);
    end
  endtask

  // Pulse set bits for one cycle; leaves the bench one cycle after the edge that latched them.
  task automatic pulse_set(input logic [NS-1:0] bits);
    set_src = bits;
    step();
    set_src = '0;
  endtask

  task automatic pulse_clr(input logic [NS-1:0] bits);
    clr_src = bits;
    step();
    clr_src = '0;
  endtask

  task automatic t_reset_state();
    chk("R10 reset state", 1'b0, 4'd0);
    step(2);
    chk("R10 idle after reset", 1'b0, 4'd0);
  endtask

  task automatic t_reset_mchk();
    crit_en = 1'b0; ext_en = 1'b0;
    pulse_set(12'b0000_0000_0011);
    step();
    chk("R1 reset first, ungated", 1'b1, 4'd0);
    step();
    chk("R2 machine check second, ungated", 1'b1, 4'd1);
    step();
    chk("R1 R2 both cleared on take", 1'b0, 4'd0);
  endtask

  task automatic t_crit();
    crit_en = 1'b0; ext_en = 1'b1;
    pulse_set(12'b0000_0000_0100);
    step(3);
    chk("R3 critical masked by crit_en=0", 1'b0, 4'd0);
    crit_en = 1'b1;
    step();
    chk("R3 critical taken", 1'b1, 4'd2);
    step();
    chk("R3 critical still pending, taken again", 1'b1, 4'd2);
    crit_en = 1'b0;
    pulse_clr(12'b0000_0000_0100);
    step();
    chk("R9 critical cleared", 1'b0, 4'd0);
    crit_en = 1'b1;
    step(2);
    chk("R9 critical not taken after clear", 1'b0, 4'd0);
    crit_en = 1'b0;
  endtask

  task automatic t_ee_order();
    logic [3:0] exp_seq [8];
    exp_seq = '{4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd9, 4'd10, 4'd11};
    ext_en = 1'b0;
    pulse_set(12'b1110_1111_1000);
    step(2);
    chk("R4 ext_en=0 blocks all", 1'b0, 4'd0);
    ext_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step();
      chk("R4 priority order", 1'b1, exp_seq[i]);
    end
    step();
    chk("R5 pulse sources cleared on take", 1'b0, 4'd0);
  endtask

  task automatic t_ext_level();
    ext_en = 1'b1;
    pulse_set(12'b0001_0000_0000);
    step();
    chk("R5 external taken", 1'b1, 4'd8);
    step();
    chk("R5 external stays pending", 1'b1, 4'd8);
    pulse_clr(12'b0001_0000_0000);
    chk("R5 last take before clear", 1'b1, 4'd8);
    step();
    chk("R9 external gone after clear", 1'b0, 4'd0);
  endtask

  task automatic t_busy();
    ext_en = 1'b1; seq_busy = 1'b1;
    pulse_set(12'b0000_1000_0000);
    step(4);
    chk("R8 no take while busy", 1'b0, 4'd0);
    seq_busy = 1'b0;
    step();
    chk("R8 take after busy falls", 1'b1, 4'd7);
    step();
    chk("R6 strobe lasts one cycle", 1'b0, 4'd0);
  endtask

  task automatic t_set_wins();
    ext_en = 1'b1;
    set_src = 12'b0000_1000_0000;
    clr_src = 12'b0000_1000_0000;
    step();
    set_src = '0; clr_src = '0;
    step();
    chk("R7 set beats clear", 1'b1, 4'd7);
    step();
    chk("R7 then cleared by take", 1'b0, 4'd0);
  endtask

  task automatic t_sw_clear();
    ext_en = 1'b0;
    pulse_set(12'b0010_0000_0000);
    pulse_clr(12'b0010_0000_0000);
    ext_en = 1'b1;
    step(3);
    chk("R9 cleared source not delivered", 1'b0, 4'd0);
  endtask

  task automatic t_latency();
    ext_en = 1'b1;
    set_src = 12'b0100_0000_0000;
    step();
    set_src = '0;
    chk("R10 no take one edge after set", 1'b0, 4'd0);
    step();
    chk("R10 take on second edge", 1'b1, 4'd10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: take=%0b code=%0d expected run to finish", take, code);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; set_src = '0; clr_src = '0;
    crit_en = 1'b0; ext_en = 1'b0; seq_busy = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(3);
    t_reset_state();
    t_reset_mchk();
    t_crit();
    t_ee_order();
    t_ext_level();
    t_busy();
    t_set_wins();
    t_sw_clear();
    t_latency();
    step(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule